// File: doc/BRIEF.md
# Cascaded TDM Serial Output Sequencer

This block sends the sampled channel results of one converter onto a serial data line that several converters share in a daisy chain. Each sample strobe captures up to six channel words and starts a frame. The frame is made of rounds, one per enabled channel. Every round opens with a one-clock frame-sync marker. A 16-bit slot for each device in the group follows, in device order. Each device drives only its own slot, and during the other slots it releases the line.

Configuration is sampled at the strobe: the group size, the device's position in the group, the number of enabled channels, a serial-clock divide select and the length of the sample period in master clocks. All timing is derived from the master clock. Outputs update once per serial clock period, which is 1, 2, 4 or 8 master clocks, and a one-cycle marker shows when they update. If the whole frame needs more serial clocks than one sample period provides, an overrun flag is raised. In that case the next strobe cuts the frame short and starts a new one.

Top module: `tdm_cascade_tx`

## Requirements
- R1: Rounds are channel-major. Round r (0-based) carries channel r's word from every device. A round lasts grp*16+1 serial clocks.
- R2: The device at position p drives its word in round-relative serial clocks 1+16p through 16+16p. It sends the word MSB first with sdo_en high. A position at or beyond the group size never drives.
- R3: Whenever sdo_en is low, sdo is 0.
- R4: fsync is high for serial clock 0 of each round and low at every other serial clock. fsync is never high together with sdo_en.
- R5: After a strobe, the outputs first update one master clock after the strobe edge and then every 2^clk_sel master clocks (clk_sel 0..3). ser_tick is high for exactly the master clock in which an update appears, and the outputs hold still in between.
- R6: After the last round, one further update drives sdo, sdo_en and fsync to 0. No further update follows until the next strobe.
- R7: Channel words and configuration inputs are captured at the strobe. Changing them during a frame does not alter that frame.
- R8: At each strobe, overrun is set to ((grp*16+1)*channels > period_mclk >> clk_sel) and held until the next strobe.
- R9: A strobe during a frame abandons that frame and starts a new one from round 0 with newly captured words.
- R10: A group size of 0 counts as 1 and one above 8 counts as 8. A channel count of 0 counts as 1 and one above 6 counts as 6.
- R11: During and after reset, before any strobe, sdo, sdo_en, fsync, ser_tick and overrun are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_stb | input | 1 | One-cycle sample strobe; captures words and configuration and starts a frame |
| chan_data | input | 96 | Channel words, channel c at bits [16c+15:16c] |
| grp_size | input | 4 | Number of devices in the group |
| grp_pos | input | 4 | This device's position in the group, 0 first |
| chan_cnt | input | 3 | Number of enabled channels |
| clk_sel | input | 2 | Serial clock divide select: divide by 2^clk_sel |
| period_mclk | input | 16 | Master clocks in one sample period |
| sdo | output | 1 | Serial data |
| sdo_en | output | 1 | High while this device owns the data line |
| fsync | output | 1 | Round-start frame sync |
| ser_tick | output | 1 | High in the master clock where the serial outputs update |
| overrun | output | 1 | Frame does not fit in one sample period |

## Verification
The hardest situation to reach from the ports is a frame that is cut short while the divider is partway through a serial period. The new frame must then restart cleanly, with a fresh phase and fresh words, while old output values are still on the line. The bench starts a frame, fires a second strobe at a cycle count that is not a multiple of the divide ratio, and checks the whole following frame tick by tick. Capture at the strobe is tested by scrambling every data and configuration input straight after each strobe of the sweep. Position-beyond-group and overrun thresholds one serial clock on either side are covered by dedicated cases.

// File: rtl/tdm_cascade_pkg.sv
package tdm_cascade_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_TAIL = 2'd2
    } seq_state_e;

endpackage

// File: rtl/tdm_sclk_div.sv
module tdm_sclk_div #(
    parameter int NUM_SEL = 4,
    localparam int SEL_W  = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1,
    localparam int CNT_W  = (NUM_SEL > 1) ? NUM_SEL - 1 : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W:0]   span;
    logic [CNT_W:0]   reload_w;

    always_comb begin
        span     = (CNT_W+1)'(1) << sel;
        reload_w = span - (CNT_W+1)'(1);
        tick     = run && !restart && (cnt_q == '0);
        cnt_d    = cnt_q;
        if (restart) begin
            cnt_d = '0;
        end else if (run) begin
            if (cnt_q == '0) cnt_d = reload_w[CNT_W-1:0];
            else             cnt_d = cnt_q - CNT_W'(1);
        end else begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/tdm_slot_map.sv
module tdm_slot_map #(
    parameter int WORD_W  = 16,
    parameter int MAX_DEV = 8,
    localparam int DEV_W  = $clog2(MAX_DEV + 1),
    localparam int BPOS_W = $clog2(MAX_DEV * WORD_W + 1),
    localparam int IDX_W  = $clog2(WORD_W),
    localparam int EXT_W  = BPOS_W + DEV_W + 1
) (
    input  logic [BPOS_W-1:0] bpos,
    input  logic [DEV_W-1:0]  grp,
    input  logic [DEV_W-1:0]  pos,
    output logic              is_sync,
    output logic              drive,
    output logic [IDX_W-1:0]  bit_idx
);

    logic [EXT_W-1:0] bpos_e, base_e, offs_e;

    always_comb begin
        bpos_e  = EXT_W'(bpos);
        base_e  = EXT_W'(pos) * EXT_W'(WORD_W);
        is_sync = (bpos == '0);
        drive   = (pos < grp) && (bpos_e > base_e)
                  && (bpos_e <= base_e + EXT_W'(WORD_W));
        offs_e  = bpos_e - base_e - EXT_W'(1);
        bit_idx = IDX_W'(WORD_W - 1) - offs_e[IDX_W-1:0];
    end

endmodule

// File: rtl/tdm_budget.sv
module tdm_budget #(
    parameter int WORD_W  = 16,
    parameter int MAX_DEV = 8,
    parameter int MAX_CH  = 6,
    parameter int PER_W   = 16,
    parameter int NUM_SEL = 4,
    localparam int DEV_W  = $clog2(MAX_DEV + 1),
    localparam int CH_W   = $clog2(MAX_CH + 1),
    localparam int SEL_W  = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1,
    localparam int NEED_W = $clog2((MAX_DEV * WORD_W + 1) * MAX_CH + 1),
    localparam int CMP_W  = (NEED_W > PER_W) ? NEED_W : PER_W
) (
    input  logic [DEV_W-1:0] grp,
    input  logic [CH_W-1:0]  nch,
    input  logic [SEL_W-1:0] sel,
    input  logic [PER_W-1:0] period,
    output logic             too_long
);

    logic [NEED_W-1:0] round_len;
    logic [NEED_W-1:0] need;
    logic [PER_W-1:0]  avail;

    always_comb begin
        round_len = NEED_W'(grp) * NEED_W'(WORD_W) + NEED_W'(1);
        need      = round_len * NEED_W'(nch);
        avail     = period >> sel;
        too_long  = CMP_W'(need) > CMP_W'(avail);
    end

endmodule

// File: rtl/tdm_word_hold.sv
module tdm_word_hold #(
    parameter int WORD_W = 16,
    parameter int MAX_CH = 6,
    localparam int CH_W  = $clog2(MAX_CH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [MAX_CH*WORD_W-1:0] words_in,
    input  logic [CH_W-1:0]          sel,
    output logic [WORD_W-1:0]        word_out
);

    logic [WORD_W-1:0] words_d [MAX_CH];
    logic [WORD_W-1:0] words_q [MAX_CH];

    for (genvar c = 0; c < MAX_CH; c++) begin : g_chan
        always_comb begin
            words_d[c] = words_q[c];
            if (load) words_d[c] = words_in[c*WORD_W +: WORD_W];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) words_q[c] <= '0;
            else        words_q[c] <= words_d[c];
        end
    end

    always_comb begin
        word_out = '0;
        for (int c = 0; c < MAX_CH; c++) begin
            if (sel == CH_W'(c)) word_out = words_q[c];
        end
    end

endmodule

// File: rtl/tdm_cascade_tx.sv
module tdm_cascade_tx
    import tdm_cascade_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int MAX_DEV = 8,
    parameter int MAX_CH  = 6,
    parameter int PER_W   = 16,
    parameter int NUM_SEL = 4,
    localparam int DEV_W  = $clog2(MAX_DEV + 1),
    localparam int CH_W   = $clog2(MAX_CH + 1),
    localparam int SEL_W  = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1,
    localparam int BPOS_W = $clog2(MAX_DEV * WORD_W + 1),
    localparam int IDX_W  = $clog2(WORD_W)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sample_stb,
    input  logic [MAX_CH*WORD_W-1:0] chan_data,
    input  logic [DEV_W-1:0]         grp_size,
    input  logic [DEV_W-1:0]         grp_pos,
    input  logic [CH_W-1:0]          chan_cnt,
    input  logic [SEL_W-1:0]         clk_sel,
    input  logic [PER_W-1:0]         period_mclk,
    output logic                     sdo,
    output logic                     sdo_en,
    output logic                     fsync,
    output logic                     ser_tick,
    output logic                     overrun
);

    typedef struct packed {
        seq_state_e        st;
        logic [BPOS_W-1:0] bpos;
        logic [CH_W-1:0]   rnd;
        logic [DEV_W-1:0]  grp;
        logic [DEV_W-1:0]  pos;
        logic [CH_W-1:0]   nch;
        logic [SEL_W-1:0]  sel;
        logic              sdo;
        logic              en;
        logic              fsync;
        logic              tick;
        logic              ovr;
    } seq_t;

    seq_t s_d, s_q;

    logic [DEV_W-1:0]  grp_c;
    logic [CH_W-1:0]   nch_c;
    logic              too_long;
    logic              tick;
    logic              map_sync;
    logic              map_drive;
    logic [IDX_W-1:0]  map_idx;
    logic [WORD_W-1:0] cur_word;
    logic [BPOS_W-1:0] rl_last;

    // Clamp the raw configuration to the supported range (R10)
    always_comb begin
        if (grp_size == '0)                       grp_c = DEV_W'(1);
        else if (grp_size > DEV_W'(MAX_DEV))      grp_c = DEV_W'(MAX_DEV);
        else                                      grp_c = grp_size;
        if (chan_cnt == '0)                       nch_c = CH_W'(1);
        else if (chan_cnt > CH_W'(MAX_CH))        nch_c = CH_W'(MAX_CH);
        else                                      nch_c = chan_cnt;
    end

    tdm_budget #(
        .WORD_W (WORD_W),
        .MAX_DEV(MAX_DEV),
        .MAX_CH (MAX_CH),
        .PER_W  (PER_W),
        .NUM_SEL(NUM_SEL)
    ) u_budget (
        .grp     (grp_c),
        .nch     (nch_c),
        .sel     (clk_sel),
        .period  (period_mclk),
        .too_long(too_long)
    );

    tdm_sclk_div #(
        .NUM_SEL(NUM_SEL)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(sample_stb),
        .run    (s_q.st != SEQ_IDLE),
        .sel    (s_q.sel),
        .tick   (tick)
    );

    tdm_word_hold #(
        .WORD_W(WORD_W),
        .MAX_CH(MAX_CH)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (sample_stb),
        .words_in(chan_data),
        .sel     (s_q.rnd),
        .word_out(cur_word)
    );

    tdm_slot_map #(
        .WORD_W (WORD_W),
        .MAX_DEV(MAX_DEV)
    ) u_map (
        .bpos   (s_q.bpos),
        .grp    (s_q.grp),
        .pos    (s_q.pos),
        .is_sync(map_sync),
        .drive  (map_drive),
        .bit_idx(map_idx)
    );

    always_comb begin
        rl_last = BPOS_W'(s_q.grp) * BPOS_W'(WORD_W);
        s_d      = s_q;
        s_d.tick = 1'b0;
        if (sample_stb) begin
            // capture configuration and restart the frame (R7, R9)
            s_d.st   = SEQ_RUN;
            s_d.bpos = '0;
            s_d.rnd  = '0;
            s_d.grp  = grp_c;
            s_d.pos  = grp_pos;
            s_d.nch  = nch_c;
            s_d.sel  = clk_sel;
            s_d.ovr  = too_long;
        end else if (tick) begin
            s_d.tick = 1'b1;
            unique case (s_q.st)
                SEQ_RUN: begin
                    s_d.fsync = map_sync;
                    s_d.en    = map_drive;
                    s_d.sdo   = map_drive & cur_word[map_idx];
                    if (s_q.bpos == rl_last) begin
                        s_d.bpos = '0;
                        if (s_q.rnd == s_q.nch - CH_W'(1)) s_d.st  = SEQ_TAIL;
                        else                               s_d.rnd = s_q.rnd + CH_W'(1);
                    end else begin
                        s_d.bpos = s_q.bpos + BPOS_W'(1);
                    end
                end
                SEQ_TAIL: begin
                    s_d.fsync = 1'b0;
                    s_d.en    = 1'b0;
                    s_d.sdo   = 1'b0;
                    s_d.st    = SEQ_IDLE;
                end
                default: s_d.st = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.st    <= SEQ_IDLE;
            s_q.grp   <= DEV_W'(1);
            s_q.nch   <= CH_W'(1);
        end else begin
            s_q <= s_d;
        end
    end

    assign sdo      = s_q.sdo;
    assign sdo_en   = s_q.en;
    assign fsync    = s_q.fsync;
    assign ser_tick = s_q.tick;
    assign overrun  = s_q.ovr;

endmodule

// File: rtl/tdm_cascade_tx_chk.sv
module tdm_cascade_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic sample_stb,
    input logic sdo,
    input logic sdo_en,
    input logic fsync,
    input logic ser_tick,
    input logic overrun
);

    // R3: a released line carries 0
    a_r3_released_line_low: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_en |-> !sdo);

    // R4: frame sync never overlaps a data slot
    a_r4_sync_apart_from_data: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |-> !sdo_en);

    // R5: serial outputs only move on an update cycle
    a_r5_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_tick |-> $stable({sdo, sdo_en, fsync}));

    // R5: no update in the cycle right after a strobe edge
    a_r5_no_tick_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !ser_tick);

    // R8: overrun moves only at a strobe
    a_r8_flag_held: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |=> $stable(overrun));

endmodule

bind tdm_cascade_tx tdm_cascade_tx_chk u_chk (.*);

// File: tb/tb_tdm_cascade_tx.sv
module tb_tdm_cascade_tx;

    localparam int W = 16;
    localparam int NCH = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sample_stb = 1'b0;
    logic [NCH*W-1:0] chan_data = '0;
    logic [3:0]    grp_size = 4'd1;
    logic [3:0]    grp_pos = 4'd0;
    logic [2:0]    chan_cnt = 3'd1;
    logic [1:0]    clk_sel = 2'd0;
    logic [15:0]   period_mclk = 16'hFFFF;
    logic          sdo, sdo_en, fsync, ser_tick, overrun;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    logic [W-1:0] exp_w [NCH];

    always #10 clk = ~clk;

    tdm_cascade_tx dut (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .chan_data(chan_data),
        .grp_size(grp_size), .grp_pos(grp_pos), .chan_cnt(chan_cnt),
        .clk_sel(clk_sel), .period_mclk(period_mclk),
        .sdo(sdo), .sdo_en(sdo_en), .fsync(fsync), .ser_tick(ser_tick),
        .overrun(overrun)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_errors++;
            $display("FAIL watchdog expired actual=%0d expected=<190000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    // Pulse a strobe with fresh words and the given raw configuration.
    task automatic strobe(input int sel, input int grp, input int pos, input int ch,
                          input int period);
        @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            exp_w[c] = W'($urandom);
            chan_data[c*W +: W] = exp_w[c];
        end
        clk_sel = 2'(sel); grp_size = 4'(grp); grp_pos = 4'(pos);
        chan_cnt = 3'(ch); period_mclk = 16'(period);
        sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
    endtask

    // Strobe, scramble the inputs, and check the whole frame tick by tick.
    task automatic run_frame(input int sel, input int grp, input int pos, input int ch,
                             input int period);
        int eg, ec, rl, div, nt, total, need, base, r, b;
        int e_sync, e_en, e_sdo, e_time, e_tail;
        bit xs, xe, xd, drv;
        eg = (grp == 0) ? 1 : (grp > 8) ? 8 : grp;
        ec = (ch == 0) ? 1 : (ch > NCH) ? NCH : ch;
        rl = eg * W + 1;
        div = 1 << sel;
        need = rl * ec;
        base = pos * W;
        strobe(sel, grp, pos, ch, period);
        chk(overrun == (need > (period >> sel)), $sformatf("R8 overrun sel=%0d grp=%0d ch=%0d per=%0d",
            sel, grp, ch, period), int'(overrun), int'(need > (period >> sel)));
        // R7: everything changes right after capture
        chan_data = ~chan_data;
        grp_size = 4'($urandom); grp_pos = 4'($urandom);
        chan_cnt = 3'($urandom); clk_sel = 2'($urandom);
        nt = 0; e_sync = 0; e_en = 0; e_sdo = 0; e_time = 0; e_tail = 0;
        total = (need + 1) * div + 16;
        for (int c = 1; c <= total; c++) begin
            @(negedge clk);
            if (ser_tick) begin
                if (c != 1 + nt * div) e_time++;
                if (nt < need) begin
                    r = nt / rl; b = nt % rl;
                    drv = (pos < eg) && (b > base) && (b <= base + W);
                    xs = (b == 0);
                    xe = drv;
                    xd = drv ? exp_w[r][W-1-(b-1-base)] : 1'b0;
                    if (fsync !== xs) e_sync++;
                    if (sdo_en !== xe) e_en++;
                    if (sdo !== xd) e_sdo++;
                end else if (nt == need) begin
                    if (fsync !== 1'b0 || sdo_en !== 1'b0 || sdo !== 1'b0) e_tail++;
                end
                nt++;
            end
        end
        chk(e_sync == 0, $sformatf("R4 fsync mismatches sel=%0d grp=%0d pos=%0d ch=%0d",
            sel, grp, pos, ch), e_sync, 0);
        chk(e_en == 0, $sformatf("R2 R3 sdo_en mismatches sel=%0d grp=%0d pos=%0d ch=%0d",
            sel, grp, pos, ch), e_en, 0);
        chk(e_sdo == 0, $sformatf("R1 R7 sdo mismatches sel=%0d grp=%0d pos=%0d ch=%0d",
            sel, grp, pos, ch), e_sdo, 0);
        chk(e_time == 0, $sformatf("R5 tick timing mismatches sel=%0d grp=%0d ch=%0d",
            sel, grp, ch), e_time, 0);
        chk(nt == need + 1 && e_tail == 0, $sformatf("R6 update count sel=%0d grp=%0d ch=%0d tail_err=%0d",
            sel, grp, ch, e_tail), nt, need + 1);
    endtask

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        chk({sdo, sdo_en, fsync, ser_tick, overrun} == 5'b0, "R11 outputs in reset",
            int'({sdo, sdo_en, fsync, ser_tick, overrun}), 0);
        rst_n = 1'b1;
        begin
            int seen;
            seen = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if ({sdo, sdo_en, fsync, ser_tick, overrun} != 5'b0) seen++;
            end
            chk(seen == 0, "R11 idle after reset", seen, 0);
        end

        // Sweep: all divides, groups 1..3, every position incl. one past the group
        for (int sel = 0; sel < 4; sel++)
            for (int grp = 1; grp <= 3; grp++)
                for (int pos = 0; pos <= grp; pos++)
                    for (int ci = 0; ci < 3; ci++)
                        run_frame(sel, grp, pos, (ci == 2) ? 6 : ci + 1, 16'hFFFF);

        // R10: clamping of channel count and group size
        run_frame(0, 1, 0, 0, 16'hFFFF);
        run_frame(0, 1, 0, 7, 16'hFFFF);
        run_frame(0, 0, 0, 1, 16'hFFFF);
        run_frame(0, 9, 7, 1, 16'hFFFF);

        // R8: budget boundary, need = 49*6 = 294 serial clocks at divide 8
        run_frame(3, 3, 1, 6, 2352);
        run_frame(3, 3, 1, 6, 2344);
        run_frame(0, 8, 7, 6, 774);
        run_frame(0, 8, 7, 6, 773);

        // R9: strobe in the middle of a frame, off the divide phase
        strobe(2, 2, 1, 3, 16'hFFFF);
        repeat (150) @(negedge clk);
        run_frame(1, 3, 2, 2, 16'hFFFF);
        strobe(3, 3, 0, 6, 200);
        repeat (77) @(negedge clk);
        run_frame(2, 2, 0, 3, 16'hFFFF);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule